// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Block

This block is a two-port shared RAM with a pair of mailbox words at the top of its address space, used by two agents to signal each other. Each agent has its own port, and each port has its own interrupt flag.

When one port writes to its outgoing mailbox word, the flag of the other port goes active. When the flagged port later reads that same word, its flag is cleared. The mailbox words also store data like any other location, so the receiving agent can read a message value in the same access that acknowledges the interrupt.

Both ports are synchronous to one clock. Writes take effect at the clock edge. Read data appears on the port one cycle after the read is issued.

Top module: `dpmbx_top`

## Requirements
- R1: After reset both interrupt outputs are high (inactive) and both read-data outputs are zero.
- R2: A left-port write (sel=1, wr=1) to address 0x7FF (all ones) drives `r_irq_n` low from the next clock edge.
- R3: A right-port read of 0x7FF clears the right flag, so `r_irq_n` is high from the next edge.
- R4: A right-port write to 0x7FE (all ones minus one) drives `l_irq_n` low from the next edge.
- R5: A left-port read of 0x7FE drives `l_irq_n` high from the next edge.
- R6: A read counts toward clearing only when sel=1, oe=1 and wr=0. A write with oe=1 does not clear, and neither does oe=1 with sel=0.
- R7: When a set and a clear of the same flag happen in the same cycle, the flag ends up active (low).
- R8: Every location, including both mailbox words, stores written data. A read returns it on `rdata` one cycle after the read.
- R9: Flags are unchanged by accesses to other addresses, by the owning port writing its own clear address, and by the signalling port reading its own set address.
- R10: If both ports write the same address in the same cycle, the left data is kept. A read of an address that is written in the same cycle returns the old data.
- R11: `rdata` of a port holds its last value in every cycle in which that port issues no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_sel | input | 1 | Left port select |
| l_wr | input | 1 | Left write strobe |
| l_oe | input | 1 | Left read enable |
| l_addr | input | ADDR_W | Left address |
| l_wdata | input | DATA_W | Left write data |
| l_rdata | output | DATA_W | Left read data |
| l_irq_n | output | 1 | Left interrupt, active low |
| r_sel | input | 1 | Right port select |
| r_wr | input | 1 | Right write strobe |
| r_oe | input | 1 | Right read enable |
| r_addr | input | ADDR_W | Right address |
| r_wdata | input | DATA_W | Right write data |
| r_rdata | output | DATA_W | Right read data |
| r_irq_n | output | 1 | Right interrupt, active low |

## Verification
A wrong flag state shows on the interrupt pin in the cycle after the access that caused it. The flag holds its state, so a missed set or clear stays visible until the next mailbox access. A wrong word in the array only shows when that address is next read, one cycle after the read. The random phase therefore reads the mailbox words often and compares every output in every cycle.

// File: rtl/dpmbx_pkg.sv
package dpmbx_pkg;
   typedef enum logic {PORT_L = 1'b0, PORT_R = 1'b1} port_e;

   // mailbox word a port writes to signal its peer
   function automatic logic [31:0] set_word(input int unsigned aw, input int unsigned p);
      logic [31:0] top;
      top = (32'd1 << aw) - 32'd1;
      return (p == 0) ? top : top - 32'd1;
   endfunction

   // mailbox word a port reads to acknowledge its own flag
   function automatic logic [31:0] clr_word(input int unsigned aw, input int unsigned p);
      return set_word(aw, 1 - p);
   endfunction
endpackage

// File: rtl/dpmbx_decode.sv
module dpmbx_decode #(
   parameter int ADDR_W   = 11,
   parameter int SET_ADDR = 2047,
   parameter int CLR_ADDR = 2046
) (
   input  logic              sel,
   input  logic              wr,
   input  logic              oe,
   input  logic [ADDR_W-1:0] addr,
   output logic              wr_en,
   output logic              rd_en,
   output logic              set_hit,
   output logic              clr_hit
);
   localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(SET_ADDR);
   localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(CLR_ADDR);

   always_comb begin
      wr_en   = sel & wr;
      rd_en   = sel & oe & ~wr;
      set_hit = wr_en & (addr == SET_A);
      clr_hit = rd_en & (addr == CLR_A);
   end
endmodule

// File: rtl/dpmbx_flag.sv
module dpmbx_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic irq_n
);
   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag_q <= 1'b0;
      else if (set)    flag_q <= 1'b1;
      else if (clr)    flag_q <= 1'b0;
   end

   assign irq_n = ~flag_q;

   a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> !irq_n);
   a_r3_clear_releases: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !set) |=> irq_n);
   a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!set && !clr) |=> $stable(irq_n));
endmodule

// File: rtl/dpmbx_ram.sv
module dpmbx_ram #(
   parameter int ADDR_W = 11,
   parameter int DATA_W = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [1:0]             wr_en,
   input  logic [1:0]             rd_en,
   input  logic [1:0][ADDR_W-1:0] addr,
   input  logic [1:0][DATA_W-1:0] wdata,
   output logic [1:0][DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   // right first, left last: the left port wins a same-word collision
   always_ff @(posedge clk) begin
      if (wr_en[1]) mem[addr[1]] <= wdata[1];
      if (wr_en[0]) mem[addr[0]] <= wdata[0];
   end

   for (genvar p = 0; p < 2; p++) begin : g_rd
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        rdata[p] <= '0;
         else if (rd_en[p]) rdata[p] <= mem[addr[p]];
      end

      a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
         !rd_en[p] |=> $stable(rdata[p]));
   end
endmodule

// File: rtl/dpmbx_top.sv
module dpmbx_top #(
   parameter int ADDR_W = 11,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              l_sel,
   input  logic              l_wr,
   input  logic              l_oe,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic [DATA_W-1:0] l_wdata,
   output logic [DATA_W-1:0] l_rdata,
   output logic              l_irq_n,
   input  logic              r_sel,
   input  logic              r_wr,
   input  logic              r_oe,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic [DATA_W-1:0] r_wdata,
   output logic [DATA_W-1:0] r_rdata,
   output logic              r_irq_n
);
   import dpmbx_pkg::*;

   if (ADDR_W < 2 || ADDR_W > 16) begin : g_bad_aw
      $error("dpmbx_top: ADDR_W must be within 2..16");
   end
   if (DATA_W < 1) begin : g_bad_dw
      $error("dpmbx_top: DATA_W must be positive");
   end

   logic [1:0]             sel, wr, oe, wr_en, rd_en, set_hit, clr_hit, irq_n;
   logic [1:0][ADDR_W-1:0] addr;
   logic [1:0][DATA_W-1:0] wdata, rdata;

   assign sel   = {r_sel, l_sel};
   assign wr    = {r_wr, l_wr};
   assign oe    = {r_oe, l_oe};
   assign addr  = {r_addr, l_addr};
   assign wdata = {r_wdata, l_wdata};

   for (genvar p = 0; p < 2; p++) begin : g_port
      dpmbx_decode #(
         .ADDR_W  (ADDR_W),
         .SET_ADDR(int'(set_word(ADDR_W, p))),
         .CLR_ADDR(int'(clr_word(ADDR_W, p)))
      ) i_dec (
         .sel    (sel[p]),
         .wr     (wr[p]),
         .oe     (oe[p]),
         .addr   (addr[p]),
         .wr_en  (wr_en[p]),
         .rd_en  (rd_en[p]),
         .set_hit(set_hit[p]),
         .clr_hit(clr_hit[p])
      );

      // flag p belongs to port p: set by the peer, cleared by its owner
      dpmbx_flag i_flag (
         .clk  (clk),
         .rst_n(rst_n),
         .set  (set_hit[1-p]),
         .clr  (clr_hit[p]),
         .irq_n(irq_n[p])
      );
   end

   dpmbx_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_ram (
      .clk  (clk),
      .rst_n(rst_n),
      .wr_en(wr_en),
      .rd_en(rd_en),
      .addr (addr),
      .wdata(wdata),
      .rdata(rdata)
   );

   assign l_rdata = rdata[PORT_L];
   assign r_rdata = rdata[PORT_R];
   assign l_irq_n = irq_n[PORT_L];
   assign r_irq_n = irq_n[PORT_R];

   a_r2_left_write_flags_right: assert property (@(posedge clk) disable iff (!rst_n)
      (l_sel && l_wr && (&l_addr)) |=> !r_irq_n);
endmodule

// File: tb/test_dpmbx_top.sv
`timescale 1ns/1ps
module test_dpmbx_top;
   localparam int AW = 11;
   localparam int DW = 8;
   localparam logic [AW-1:0] TOP = 11'h7FF;
   localparam logic [AW-1:0] TOPM = 11'h7FE;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic l_sel = 0, l_wr = 0, l_oe = 0, r_sel = 0, r_wr = 0, r_oe = 0;
   logic [AW-1:0] l_addr = '0, r_addr = '0;
   logic [DW-1:0] l_wdata = '0, r_wdata = '0;
   logic [DW-1:0] l_rdata, r_rdata;
   logic l_irq_n, r_irq_n;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   logic [DW-1:0] m_mem [1 << AW];
   logic [DW-1:0] m_lrd = '0, m_rrd = '0;
   logic m_lflag = 0, m_rflag = 0;

   always #2 clk = ~clk;

   dpmbx_top #(.ADDR_W(AW), .DATA_W(DW)) i_dpmbx_top (
      .clk(clk), .rst_n(rst_n),
      .l_sel(l_sel), .l_wr(l_wr), .l_oe(l_oe), .l_addr(l_addr), .l_wdata(l_wdata),
      .l_rdata(l_rdata), .l_irq_n(l_irq_n),
      .r_sel(r_sel), .r_wr(r_wr), .r_oe(r_oe), .r_addr(r_addr), .r_wdata(r_wdata),
      .r_rdata(r_rdata), .r_irq_n(r_irq_n)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic bit is_rd(input logic s, input logic w, input logic o);
      return s & o & ~w;
   endfunction

   // one clock of the reference model, then compare every output mid-cycle
   task automatic step(input string req);
      bit lrd, rrd, lwe, rwe, lset, rset, lclr, rclr;
      @(posedge clk);
      lrd = is_rd(l_sel, l_wr, l_oe);
      rrd = is_rd(r_sel, r_wr, r_oe);
      lwe = l_sel & l_wr;
      rwe = r_sel & r_wr;
      if (lrd) m_lrd = m_mem[l_addr];
      if (rrd) m_rrd = m_mem[r_addr];
      if (rwe) m_mem[r_addr] = r_wdata;
      if (lwe) m_mem[l_addr] = l_wdata;
      rset = lwe && (l_addr == TOP);
      rclr = rrd && (r_addr == TOP);
      lset = rwe && (r_addr == TOPM);
      lclr = lrd && (l_addr == TOPM);
      m_rflag = rset ? 1'b1 : (rclr ? 1'b0 : m_rflag);
      m_lflag = lset ? 1'b1 : (lclr ? 1'b0 : m_lflag);
      @(negedge clk);
      check(l_irq_n === ~m_lflag, req, "l_irq_n", 32'(l_irq_n), 32'(~m_lflag));
      check(r_irq_n === ~m_rflag, req, "r_irq_n", 32'(r_irq_n), 32'(~m_rflag));
      check(l_rdata === m_lrd, req, "l_rdata", 32'(l_rdata), 32'(m_lrd));
      check(r_rdata === m_rrd, req, "r_rdata", 32'(r_rdata), 32'(m_rrd));
   endtask

   task automatic drv(input bit ls, input bit lw, input bit lo, input logic [AW-1:0] la,
                      input logic [DW-1:0] ld, input bit rs, input bit rw, input bit ro,
                      input logic [AW-1:0] ra, input logic [DW-1:0] rd);
      l_sel = ls; l_wr = lw; l_oe = lo; l_addr = la; l_wdata = ld;
      r_sel = rs; r_wr = rw; r_oe = ro; r_addr = ra; r_wdata = rd;
   endtask

   function automatic logic [AW-1:0] pick_addr(input int unsigned r);
      case (r % 6)
         0, 1:    return TOP;
         2, 3:    return TOPM;
         4:       return AW'(r >> 8) & 11'h00F;
         default: return AW'(r >> 4);
      endcase
   endfunction

   initial begin
      #200000;
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      int unsigned seed = 32'h1234_5678;
      int unsigned r;
      repeat (3) @(negedge clk);
      // R1: reset state
      check(l_irq_n === 1'b1, "R1", "l_irq_n", 32'(l_irq_n), 1);
      check(r_irq_n === 1'b1, "R1", "r_irq_n", 32'(r_irq_n), 1);
      check(l_rdata === '0, "R1", "l_rdata", 32'(l_rdata), 0);
      check(r_rdata === '0, "R1", "r_rdata", 32'(r_rdata), 0);
      rst_n = 1'b1;
      @(negedge clk);
      // fill every word from the left port
      for (int a = 0; a < (1 << AW); a++) begin
         drv(1, 1, 0, AW'(a), DW'(a * 7 + 3), 0, 0, 0, '0, '0);
         step("R8");
      end
      drv(0, 0, 0, '0, '0, 1, 0, 1, TOP, '0);          step("R3");
      drv(1, 1, 0, TOP, 8'hA5, 0, 0, 0, '0, '0);       step("R2");
      drv(0, 0, 0, '0, '0, 1, 1, 1, TOP, 8'h11);       step("R6");
      drv(0, 0, 0, '0, '0, 0, 0, 1, TOP, '0);          step("R6");
      drv(0, 0, 0, '0, '0, 1, 0, 1, TOP, '0);          step("R3");
      drv(1, 1, 0, TOP, 8'hA5, 0, 0, 0, '0, '0);       step("R2");
      drv(0, 0, 0, '0, '0, 1, 0, 1, TOP, '0);          step("R8");
      drv(0, 0, 0, '0, '0, 1, 1, 0, TOPM, 8'h3C);      step("R4");
      drv(1, 1, 0, TOPM, 8'h77, 0, 0, 0, '0, '0);      step("R9");
      drv(0, 0, 0, '0, '0, 1, 0, 1, TOPM, '0);         step("R9");
      drv(1, 0, 1, TOP, '0, 1, 1, 0, 11'h010, 8'h01);  step("R9");
      drv(1, 0, 1, TOPM, '0, 1, 1, 0, TOPM, 8'h5A);    step("R7");
      drv(1, 0, 1, TOPM, '0, 0, 0, 0, '0, '0);         step("R5");
      drv(1, 1, 0, 11'h005, 8'hAA, 1, 1, 0, 11'h005, 8'h55); step("R10");
      drv(1, 0, 1, 11'h005, '0, 1, 0, 1, 11'h005, '0);       step("R10");
      drv(1, 1, 0, 11'h006, 8'hC3, 1, 0, 1, 11'h006, '0);    step("R10");
      drv(0, 0, 0, '0, '0, 0, 0, 0, '0, '0);           step("R11");
      drv(0, 1, 1, 11'h006, '0, 0, 0, 1, 11'h006, '0); step("R11");
      // random mix; flag and data outputs compared each cycle
      void'($urandom(seed));
      for (int i = 0; i < 3000; i++) begin
         r = $urandom;
         drv(r[0], r[1] & r[2], r[3], pick_addr($urandom), DW'($urandom),
             r[4], r[5] & r[6], r[7], pick_addr($urandom), DW'($urandom));
         step((i % 2) ? "R8" : "R9");
      end
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule